// File: doc/BRIEF.md
# Overriding Two-Level Branch Direction Predictor

This block predicts whether a conditional branch is taken, using two levels of state. The fast level is an untagged table of two-bit saturating counters. It is indexed by the low PC bits XORed with a short slice of the global history, and it answers combinationally in the cycle of the lookup. The slow level is a small direct-mapped table with tags. It is indexed and tagged with a longer global history folded down to size. It only learns branches that the fast level got wrong, and one cycle after the lookup it confirms the early guess or reverses it.

A fetch unit presents a PC with `lk_valid` and steers on `early_taken` at once. One cycle later it reads `late_taken`. When `late_override` is high it redirects, and the lookup it presents in that same cycle is treated as squashed. When a branch retires, the back end returns its PC, its real direction and the history snapshot it was predicted with. The block then recomputes its own prediction from that snapshot, trains both levels, and repairs the history register if the prediction was wrong.

Top module: `bp_overriding_predictor`

## Requirements
- R1: After a synchronous active-high reset, every counter in both levels reads 2'b01 (weakly not-taken), every slow-level entry is invalid, the history register is zero, and `late_valid` and `late_override` are low.
- R2: `early_taken` is the upper bit of the fast counter at index `lk_pc[L1_IDX_W-1:0] ^ ghr[L1_HIST_W-1:0]`, in the same cycle as the lookup, where `ghr` bit 0 is the newest outcome.
- R3: Every resolve steps the fast counter at `rs_pc[L1_IDX_W-1:0] ^ rs_hist[L1_HIST_W-1:0]` by one toward `rs_taken`, saturating at 2'b00 and 2'b11.
- R4: A resolve that misses the slow level, and whose fast-level direction differs from `rs_taken`, fills the addressed slow entry: valid, the new tag, and counter 2'b10 if taken or 2'b01 if not. No other resolve fills an entry.
- R5: The slow index is `pc[L2_IDX_W-1:0]` XOR the history folded to L2_IDX_W bits, where history bit i lands on bit i mod L2_IDX_W. The tag is the PC bits above the index folded to TAG_W bits, where PC bit j lands on bit (j-L2_IDX_W) mod TAG_W, XOR the history folded to TAG_W bits. A hit needs a valid entry with an equal tag.
- R6: `late_valid` is high exactly one cycle after an accepted lookup. `late_taken` is then the slow counter's upper bit on a hit, and otherwise the early guess.
- R7: `late_override` is high exactly when the late result is a slow-level hit whose direction differs from the early guess. A lookup that is presented in an override cycle is dropped: it produces no late result and does not shift the history.
- R8: An accepted lookup shifts its early guess into bit 0 of the history. In an override cycle, history bit 0 is inverted instead.
- R9: A resolve whose combined prediction (slow on a hit, otherwise fast) differs from `rs_taken` loads the history with `{rs_hist[HIST_W-2:0], rs_taken}`. This takes priority over both the override and the lookup.
- R10: A resolve that hits a slow entry steps that entry's counter toward `rs_taken`, saturating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | PC_W | Lookup PC |
| early_taken | output | 1 | Same-cycle fast-level direction |
| late_valid | output | 1 | Late result present for last cycle's lookup |
| late_taken | output | 1 | Final direction for that lookup |
| late_override | output | 1 | Late direction reverses the early guess |
| rs_valid | input | 1 | Resolve request |
| rs_pc | input | PC_W | PC of the resolved branch |
| rs_taken | input | 1 | Actual direction |
| rs_hist | input | HIST_W | History snapshot the branch was predicted with |

## Verification
The bench builds the block with a 16-bit PC and only eight slow-level entries, and keeps the other sizes at their defaults. With so few slow entries, unrelated branches collide and replace each other's tags after a few dozen resolves. Hand-chosen PCs can therefore land on one slow entry while hitting or missing its tag on purpose, which sets up overrides, squashed lookups and history flips in a handful of cycles. The full 16-bit history is kept, so the folding of history bits onto the index and tag is still exercised.

// File: rtl/bp_pkg.sv
`timescale 1ns/1ps
package bp_pkg;
    localparam logic [1:0] CTR_WEAK_NT = 2'b01;
    localparam logic [1:0] CTR_WEAK_T  = 2'b10;

    // Saturating two-bit counter step toward the outcome.
    function automatic logic [1:0] ctr_step(input logic [1:0] c, input logic up);
        if (up) return (c == 2'b11) ? c : c + 2'd1;
        return (c == 2'b00) ? c : c - 2'd1;
    endfunction
endpackage

// File: rtl/bp_hash.sv
`timescale 1ns/1ps
module bp_hash #(
    parameter int PC_W      = 32,
    parameter int L1_IDX_W  = 8,
    parameter int L1_HIST_W = 8,
    parameter int L2_IDX_W  = 6,
    parameter int HIST_W    = 16,
    parameter int TAG_W     = 8
) (
    input  logic [PC_W-1:0]     pc,
    input  logic [HIST_W-1:0]   hist,
    output logic [L1_IDX_W-1:0] l1_idx,
    output logic [L2_IDX_W-1:0] l2_idx,
    output logic [TAG_W-1:0]    l2_tag
);
    logic [L1_IDX_W-1:0] short_hist;

    always_comb begin
        // fast level: short history, gshare-like
        short_hist = '0;
        short_hist[L1_HIST_W-1:0] = hist[L1_HIST_W-1:0];
        l1_idx = pc[L1_IDX_W-1:0] ^ short_hist;

        // slow level: whole history folded onto index and tag
        l2_idx = pc[L2_IDX_W-1:0];
        l2_tag = '0;
        for (int i = 0; i < HIST_W; i++) begin
            l2_idx[i % L2_IDX_W] ^= hist[i];
            l2_tag[i % TAG_W]    ^= hist[i];
        end
        for (int j = L2_IDX_W; j < PC_W; j++) begin
            l2_tag[(j - L2_IDX_W) % TAG_W] ^= pc[j];
        end
    end
endmodule

// File: rtl/bp_l1_table.sv
`timescale 1ns/1ps
module bp_l1_table
    import bp_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] look_idx,
    output logic [1:0]       look_ctr,
    input  logic [IDX_W-1:0] upd_idx,
    output logic [1:0]       upd_ctr,
    input  logic             upd_en,
    input  logic             upd_taken
);
    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic [DEPTH-1:0][1:0] ctr;
    } l1_state_t;

    l1_state_t state_d, state_q;

    always_comb begin
        look_ctr = state_q.ctr[look_idx];
        upd_ctr  = state_q.ctr[upd_idx];
        state_d  = state_q;
        if (upd_en) begin
            state_d.ctr[upd_idx] = ctr_step(state_q.ctr[upd_idx], upd_taken);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q.ctr <= {DEPTH{CTR_WEAK_NT}};
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/bp_l2_table.sv
`timescale 1ns/1ps
module bp_l2_table
    import bp_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    // late read for the pending lookup
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             rd_hit,
    output logic             rd_dir,
    // resolve side
    input  logic [IDX_W-1:0] up_idx,
    input  logic [TAG_W-1:0] up_tag,
    output logic             up_hit,
    output logic             up_dir,
    input  logic             up_en,
    input  logic             up_taken,
    input  logic             up_fast_wrong
);
    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic [DEPTH-1:0]            valid;
        logic [DEPTH-1:0][TAG_W-1:0] tag;
        logic [DEPTH-1:0][1:0]       ctr;
    } l2_state_t;

    l2_state_t state_d, state_q;

    always_comb begin
        rd_hit = state_q.valid[rd_idx] && (state_q.tag[rd_idx] == rd_tag);
        rd_dir = state_q.ctr[rd_idx][1];
        up_hit = state_q.valid[up_idx] && (state_q.tag[up_idx] == up_tag);
        up_dir = state_q.ctr[up_idx][1];

        state_d = state_q;
        if (up_en) begin
            if (up_hit) begin
                state_d.ctr[up_idx] = ctr_step(state_q.ctr[up_idx], up_taken);
            end else if (up_fast_wrong) begin
                state_d.valid[up_idx] = 1'b1;
                state_d.tag[up_idx]   = up_tag;
                state_d.ctr[up_idx]   = up_taken ? CTR_WEAK_T : CTR_WEAK_NT;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q.valid <= '0;
            state_q.tag   <= '0;
            state_q.ctr   <= {DEPTH{CTR_WEAK_NT}};
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/bp_overriding_predictor.sv
`timescale 1ns/1ps
module bp_overriding_predictor
    import bp_pkg::*;
#(
    parameter int PC_W      = 32,
    parameter int L1_IDX_W  = 8,
    parameter int L1_HIST_W = 8,
    parameter int L2_IDX_W  = 6,
    parameter int HIST_W    = 16,
    parameter int TAG_W     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [PC_W-1:0]   lk_pc,
    output logic              early_taken,
    output logic              late_valid,
    output logic              late_taken,
    output logic              late_override,
    input  logic              rs_valid,
    input  logic [PC_W-1:0]   rs_pc,
    input  logic              rs_taken,
    input  logic [HIST_W-1:0] rs_hist
);
    typedef struct packed {
        logic [HIST_W-1:0]   ghr;
        logic                pend_valid;
        logic                pend_early;
        logic [L2_IDX_W-1:0] pend_idx;
        logic [TAG_W-1:0]    pend_tag;
    } top_state_t;

    top_state_t state_d, state_q;

    logic [L1_IDX_W-1:0] lk_l1_idx, rs_l1_idx;
    logic [L2_IDX_W-1:0] lk_l2_idx, rs_l2_idx;
    logic [TAG_W-1:0]    lk_l2_tag, rs_l2_tag;
    logic [1:0]          lk_ctr, rs_ctr;
    logic                late_hit, late_dir;
    logic                rs_hit, rs_dir;
    logic                rs_fast_dir, rs_final, rs_wrong;

    bp_hash #(
        .PC_W(PC_W), .L1_IDX_W(L1_IDX_W), .L1_HIST_W(L1_HIST_W),
        .L2_IDX_W(L2_IDX_W), .HIST_W(HIST_W), .TAG_W(TAG_W)
    ) u_hash_look (
        .pc(lk_pc), .hist(state_q.ghr),
        .l1_idx(lk_l1_idx), .l2_idx(lk_l2_idx), .l2_tag(lk_l2_tag)
    );

    bp_hash #(
        .PC_W(PC_W), .L1_IDX_W(L1_IDX_W), .L1_HIST_W(L1_HIST_W),
        .L2_IDX_W(L2_IDX_W), .HIST_W(HIST_W), .TAG_W(TAG_W)
    ) u_hash_res (
        .pc(rs_pc), .hist(rs_hist),
        .l1_idx(rs_l1_idx), .l2_idx(rs_l2_idx), .l2_tag(rs_l2_tag)
    );

    bp_l1_table #(.IDX_W(L1_IDX_W)) u_fast (
        .clk(clk), .rst(rst),
        .look_idx(lk_l1_idx), .look_ctr(lk_ctr),
        .upd_idx(rs_l1_idx), .upd_ctr(rs_ctr),
        .upd_en(rs_valid), .upd_taken(rs_taken)
    );

    bp_l2_table #(.IDX_W(L2_IDX_W), .TAG_W(TAG_W)) u_slow (
        .clk(clk), .rst(rst),
        .rd_idx(state_q.pend_idx), .rd_tag(state_q.pend_tag),
        .rd_hit(late_hit), .rd_dir(late_dir),
        .up_idx(rs_l2_idx), .up_tag(rs_l2_tag),
        .up_hit(rs_hit), .up_dir(rs_dir),
        .up_en(rs_valid), .up_taken(rs_taken),
        .up_fast_wrong(rs_fast_dir != rs_taken)
    );

    always_comb begin
        early_taken   = lk_ctr[1];

        late_valid    = state_q.pend_valid;
        late_taken    = (state_q.pend_valid && late_hit) ? late_dir : state_q.pend_early;
        late_override = state_q.pend_valid && late_hit && (late_dir != state_q.pend_early);

        rs_fast_dir   = rs_ctr[1];
        rs_final      = rs_hit ? rs_dir : rs_fast_dir;
        rs_wrong      = rs_valid && (rs_final != rs_taken);

        state_d            = state_q;
        state_d.pend_valid = lk_valid && !late_override;
        state_d.pend_early = early_taken;
        state_d.pend_idx   = lk_l2_idx;
        state_d.pend_tag   = lk_l2_tag;

        if (rs_wrong) begin
            state_d.ghr = {rs_hist[HIST_W-2:0], rs_taken};
        end else if (late_override) begin
            state_d.ghr = {state_q.ghr[HIST_W-1:1], ~state_q.ghr[0]};
        end else if (lk_valid) begin
            state_d.ghr = {state_q.ghr[HIST_W-2:0], early_taken};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/bp_overriding_predictor_chk.sv
`timescale 1ns/1ps
module bp_overriding_predictor_chk (
    input logic clk,
    input logic rst,
    input logic lk_valid,
    input logic early_taken,
    input logic late_valid,
    input logic late_taken,
    input logic late_override
);
    a_r7_override_has_result: assert property (@(posedge clk) disable iff (rst)
        late_override |-> late_valid);

    a_r7_override_reverses: assert property (@(posedge clk) disable iff (rst)
        late_override |-> (late_taken != $past(early_taken)));

    a_r6_plain_keeps_early: assert property (@(posedge clk) disable iff (rst)
        (late_valid && !late_override) |-> (late_taken == $past(early_taken)));

    a_r6_result_follows_lookup: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && !late_override) |=> late_valid);

    a_r6_no_result_without_lookup: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !late_valid);

    a_r7_squash_after_override: assert property (@(posedge clk) disable iff (rst)
        late_override |=> !late_valid);
endmodule

bind bp_overriding_predictor bp_overriding_predictor_chk u_chk (
    .clk(clk),
    .rst(rst),
    .lk_valid(lk_valid),
    .early_taken(early_taken),
    .late_valid(late_valid),
    .late_taken(late_taken),
    .late_override(late_override)
);

// File: tb/tb_bp_overriding_predictor.sv
`timescale 1ns/1ps
module tb_bp_overriding_predictor;
    localparam int PC_W = 16, L1_IDX_W = 8, L1_HIST_W = 8, L2_IDX_W = 3, HIST_W = 16, TAG_W = 8;
    localparam int L1_D = 1 << L1_IDX_W, L2_D = 1 << L2_IDX_W;

    logic clk = 1'b0, rst = 1'b1;
    logic lk_valid = 1'b0, rs_valid = 1'b0, rs_taken = 1'b0;
    logic [PC_W-1:0] lk_pc = '0, rs_pc = '0;
    logic [HIST_W-1:0] rs_hist = '0;
    logic early_taken, late_valid, late_taken, late_override;

    always #2 clk = ~clk;

    bp_overriding_predictor #(
        .PC_W(PC_W), .L1_IDX_W(L1_IDX_W), .L1_HIST_W(L1_HIST_W),
        .L2_IDX_W(L2_IDX_W), .HIST_W(HIST_W), .TAG_W(TAG_W)
    ) dut (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_pc(lk_pc),
        .early_taken(early_taken), .late_valid(late_valid),
        .late_taken(late_taken), .late_override(late_override),
        .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken), .rs_hist(rs_hist)
    );

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // independent model built from the requirements
    logic [1:0]        m_l1 [L1_D];
    logic              m_v  [L2_D];
    logic [TAG_W-1:0]  m_tag[L2_D];
    logic [1:0]        m_c  [L2_D];
    logic [HIST_W-1:0] m_ghr;
    logic              p_v, p_early;
    logic [L2_IDX_W-1:0] p_idx;
    logic [TAG_W-1:0]  p_tag;
    logic s_early, s_lv, s_lt, s_ov;

    function automatic logic [1:0] sat(input logic [1:0] c, input logic t);
        if (t) return (c == 2'd3) ? 2'd3 : c + 2'd1;
        return (c == 2'd0) ? 2'd0 : c - 2'd1;
    endfunction

    function automatic logic [L1_IDX_W-1:0] f_l1(input logic [PC_W-1:0] pc, input logic [HIST_W-1:0] h);
        return pc[L1_IDX_W-1:0] ^ h[L1_HIST_W-1:0];
    endfunction

    function automatic logic [L2_IDX_W-1:0] f_l2i(input logic [PC_W-1:0] pc, input logic [HIST_W-1:0] h);
        logic [L2_IDX_W-1:0] r = pc[L2_IDX_W-1:0];
        for (int i = 0; i < HIST_W; i++) r[i % L2_IDX_W] ^= h[i];
        return r;
    endfunction

    function automatic logic [TAG_W-1:0] f_l2t(input logic [PC_W-1:0] pc, input logic [HIST_W-1:0] h);
        logic [TAG_W-1:0] r = '0;
        for (int j = L2_IDX_W; j < PC_W; j++) r[(j - L2_IDX_W) % TAG_W] ^= pc[j];
        for (int i = 0; i < HIST_W; i++) r[i % TAG_W] ^= h[i];
        return r;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < L1_D; i++) m_l1[i] = 2'b01;
        for (int i = 0; i < L2_D; i++) begin m_v[i] = 1'b0; m_tag[i] = '0; m_c[i] = 2'b01; end
        m_ghr = '0; p_v = 1'b0; p_early = 1'b0; p_idx = '0; p_tag = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; lk_valid = 1'b0; rs_valid = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    // one clock: drive, sample, compare with model, advance model
    task automatic cyc(input logic lv, input logic [PC_W-1:0] lpc, input logic rv,
                       input logic [PC_W-1:0] rpc, input logic rt, input logic [HIST_W-1:0] rh);
        logic l2h, e_lt, e_ov, e_early, l1d, rhit, fin, mis, n_pv;
        logic [L1_IDX_W-1:0] i1;
        logic [L2_IDX_W-1:0] i2, n_idx;
        logic [TAG_W-1:0] t2, n_tag;
        @(negedge clk);
        lk_valid = lv; lk_pc = lpc; rs_valid = rv; rs_pc = rpc; rs_taken = rt; rs_hist = rh;
        #1;
        s_early = early_taken; s_lv = late_valid; s_lt = late_taken; s_ov = late_override;

        l2h  = p_v && m_v[p_idx] && (m_tag[p_idx] == p_tag);
        e_lt = l2h ? m_c[p_idx][1] : p_early;
        e_ov = l2h && (m_c[p_idx][1] != p_early);
        chk(s_lv == p_v, "R6 late_valid", int'(s_lv), int'(p_v));
        if (p_v) chk(s_lt == e_lt, "R6 late_taken", int'(s_lt), int'(e_lt));
        chk(s_ov == e_ov, "R7 late_override", int'(s_ov), int'(e_ov));
        e_early = m_l1[f_l1(lpc, m_ghr)][1];
        if (lv) chk(s_early == e_early, "R2 early_taken", int'(s_early), int'(e_early));

        i1 = f_l1(rpc, rh); i2 = f_l2i(rpc, rh); t2 = f_l2t(rpc, rh);
        l1d  = m_l1[i1][1];
        rhit = m_v[i2] && (m_tag[i2] == t2);
        fin  = rhit ? m_c[i2][1] : l1d;
        mis  = rv && (fin != rt);

        n_pv = lv && !e_ov; n_idx = f_l2i(lpc, m_ghr); n_tag = f_l2t(lpc, m_ghr);
        if (mis)       m_ghr = {rh[HIST_W-2:0], rt};
        else if (e_ov) m_ghr[0] = ~m_ghr[0];
        else if (lv)   m_ghr = {m_ghr[HIST_W-2:0], e_early};
        if (rv) begin
            m_l1[i1] = sat(m_l1[i1], rt);
            if (rhit) m_c[i2] = sat(m_c[i2], rt);
            else if (l1d != rt) begin m_v[i2] = 1'b1; m_tag[i2] = t2; m_c[i2] = rt ? 2'b10 : 2'b01; end
        end
        p_v = n_pv; p_idx = n_idx; p_tag = n_tag; p_early = e_early;
        @(posedge clk);
    endtask

    typedef struct packed {
        logic lv; logic [15:0] lpc; logic rv; logic [15:0] rpc; logic rt; logic [15:0] rh;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{1'b1, 16'h0010, 1'b0, 16'h0000, 1'b0, 16'h0000},
        '{1'b0, 16'h0000, 1'b1, 16'h0010, 1'b1, 16'h0000},
        '{1'b1, 16'h0011, 1'b1, 16'h0010, 1'b1, 16'h0000},
        '{1'b1, 16'h0123, 1'b0, 16'h0000, 1'b0, 16'h0000},
        '{1'b0, 16'h0000, 1'b1, 16'h0123, 1'b1, 16'h0003},
        '{1'b1, 16'h0123, 1'b1, 16'h0123, 1'b1, 16'h0007},
        '{1'b1, 16'h0200, 1'b1, 16'h0200, 1'b0, 16'h00F0},
        '{1'b1, 16'hFFFF, 1'b1, 16'hFFFF, 1'b1, 16'hFFFF},
        '{1'b0, 16'h0000, 1'b1, 16'hFFFF, 1'b1, 16'hFFFF},
        '{1'b1, 16'h8001, 1'b1, 16'h0123, 1'b0, 16'h0007},
        '{1'b1, 16'h0010, 1'b0, 16'h0000, 1'b0, 16'h0000},
        '{1'b0, 16'h0000, 1'b0, 16'h0000, 1'b0, 16'h0000}
    };

    initial begin
        #800000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        logic [PC_W-1:0] rq_pc [2];
        logic [HIST_W-1:0] rq_h [2];
        logic rq_v [2];
        logic lv, rt;
        logic [PC_W-1:0] pc;
        logic [HIST_W-1:0] snap;

        model_reset();
        do_reset();
        // R1: reset state seen at the ports
        cyc(1'b1, 16'h0005, 1'b0, '0, 1'b0, '0);
        chk(s_early == 1'b0, "R1 early after reset", int'(s_early), 0);
        chk(s_lv == 1'b0, "R1 late_valid after reset", int'(s_lv), 0);
        chk(s_ov == 1'b0, "R1 override after reset", int'(s_ov), 0);

        foreach (VECS[k]) begin
            cyc(VECS[k].lv, VECS[k].lpc, VECS[k].rv, VECS[k].rpc, VECS[k].rt, VECS[k].rh);
        end

        // pattern traffic with resolves two cycles behind lookups (R5, R10 via model)
        lf = 16'hACE1;
        rq_v[0] = 1'b0; rq_v[1] = 1'b0; rq_pc[0] = '0; rq_pc[1] = '0; rq_h[0] = '0; rq_h[1] = '0;
        for (int k = 0; k < 600; k++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            pc = {5'b0, lf[2:0], 2'b0, lf[5:4], 1'b0, lf[2:0]};
            lv = lf[3] | lf[6];
            snap = m_ghr;
            rt = (^rq_h[1][3:0]) ^ rq_pc[1][8] ^ (lf[9] & lf[10] & lf[11]);
            cyc(lv, pc, rq_v[1], rq_pc[1], rt, rq_h[1]);
            rq_v[1] = rq_v[0]; rq_pc[1] = rq_pc[0]; rq_h[1] = rq_h[0];
            rq_v[0] = lv; rq_pc[0] = pc; rq_h[0] = snap;
        end

        // directed sequence with hand-derived values
        do_reset();
        cyc(1'b0, '0, 1'b1, 16'h0040, 1'b1, 16'h0000);
        cyc(1'b0, '0, 1'b1, 16'h0040, 1'b1, 16'h0000);
        cyc(1'b0, '0, 1'b1, 16'h0010, 1'b1, 16'h0000);
        cyc(1'b0, '0, 1'b1, 16'h0011, 1'b0, 16'h0101);
        cyc(1'b1, 16'h0013, 1'b0, '0, 1'b0, '0);
        chk(s_early == 1'b0, "R2 untrained entry", int'(s_early), 0);
        cyc(1'b1, 16'h00AA, 1'b0, '0, 1'b0, '0);
        chk(s_lv == 1'b1, "R6 late result present", int'(s_lv), 1);
        chk(s_lt == 1'b1, "R4 weak-taken fill overrides", int'(s_lt), 1);
        chk(s_ov == 1'b1, "R9 restored history reaches tag", int'(s_ov), 1);
        cyc(1'b1, 16'h0045, 1'b0, '0, 1'b0, '0);
        chk(s_lv == 1'b0, "R7 squashed lookup", int'(s_lv), 0);
        chk(s_early == 1'b1, "R8 flipped newest history bit", int'(s_early), 1);
        cyc(1'b0, '0, 1'b1, 16'h0040, 1'b0, 16'h0000);
        cyc(1'b1, 16'h0040, 1'b0, '0, 1'b0, '0);
        chk(s_early == 1'b1, "R3 saturated counter keeps taken", int'(s_early), 1);
        cyc(1'b0, '0, 1'b0, '0, 1'b0, '0);
        chk(s_ov == 1'b1, "R4 weak-not-taken fill overrides", int'(s_ov), 1);
        chk(s_lt == 1'b0, "R4 late direction", int'(s_lt), 0);
        cyc(1'b0, '0, 1'b1, 16'h0040, 1'b1, 16'h0000);
        cyc(1'b1, 16'h0049, 1'b0, '0, 1'b0, '0);
        chk(s_early == 1'b0, "R2 fresh entry", int'(s_early), 0);
        cyc(1'b0, '0, 1'b0, '0, 1'b0, '0);
        chk(s_ov == 1'b1, "R10 slow counter trained on hit", int'(s_ov), 1);
        chk(s_lt == 1'b1, "R10 late direction", int'(s_lt), 1);
        cyc(1'b0, '0, 1'b0, '0, 1'b0, '0);
        chk(s_lv == 1'b0, "R6 idle after result", int'(s_lv), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule